// File: doc/BRIEF.md
# Load/Store Effective Address and Alignment Unit

This unit sits in the memory stage of a 64-bit integer pipeline. In the cycle of a request it forms the effective address from a base register value and a signed 16-bit displacement. It drives the memory read or write strobe, a byte-lane enable mask and the store data. It also shapes the word coming back from memory into a register value. The memory side is combinational within the request cycle. The writeback value, its valid flag and the alignment fault are registered and appear one cycle after the request.

Seven operation classes are handled. Two address-forming operations write the computed address itself; the high form scales the displacement by 65536. The loads are a sign-extending longword load, a plain quadword load and an unaligned quadword load. The unaligned load clears the three low address bits and never faults. The stores are a longword store and a quadword store. A longword or quadword access that is not naturally aligned raises a fault. It then produces no memory strobe and no writeback.

Top module: `agu_align_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `wbValid` and `alignFault` are 0; with `reqValid` low, `memRead` and `memWrite` are 0.
- R2: Operation code 0 (address form) yields `wbData` = `baseVal` + sign-extended `disp` with `wbValid` = 1, and asserts neither memory strobe.
- R3: Operation code 1 (high address form) yields `wbData` = `baseVal` + sign-extended `disp` × 65536 with `wbValid` = 1, and asserts neither memory strobe.
- R4: Operation code 2 (longword load) at a 4-byte aligned address asserts `memRead`. The byte mask is 0x0F when address bit 2 is 0 and 0xF0 when it is 1. The writeback is the selected 32-bit half of `memRdata` (bits 31:0 or 63:32), sign-extended to 64 bits.
- R5: Operation code 3 (quadword load) at an 8-byte aligned address asserts `memRead` with mask 0xFF and writes back `memRdata` unchanged.
- R6: Operation code 4 (unaligned quadword load) drives `memAddr` with bits 2:0 cleared and asserts `memRead` with mask 0xFF. It never raises `alignFault` and writes back `memRdata` unchanged.
- R7: Operation codes 5 (longword store) and 6 (quadword store) at an aligned address assert `memWrite` with the same masks as R4/R5. `memWdata` is the low 32 bits of `storeData` copied into both halves for code 5, and all of `storeData` for code 6.
- R8: A store whose effective address has a nonzero bit 1:0 (code 5) or 2:0 (code 6) drives no `memWrite` and a zero byte mask. The next cycle it shows `alignFault` = 1 and `wbValid` = 0.
- R9: A load with code 2 or 3 at an address misaligned by the same rule drives no `memRead`. The next cycle it shows `alignFault` = 1 and `wbValid` = 0.
- R10: Results appear exactly one cycle after the request. A cycle with `reqValid` low, or with operation code 7, produces `wbValid` = 0, `alignFault` = 0 and no memory strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 3 | Operation class code (0..7) |
| baseVal | input | 64 | Base register value |
| disp | input | 16 | Signed displacement |
| storeData | input | 64 | Register value to store |
| memRdata | input | 64 | Aligned 64-bit read word from memory, same cycle |
| memAddr | output | 64 | Effective address to memory |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| memByteEn | output | 8 | Byte-lane enable mask |
| memWdata | output | 64 | Store data placed on byte lanes |
| wbValid | output | 1 | Registered writeback valid |
| wbData | output | 64 | Registered writeback value |
| alignFault | output | 1 | Registered alignment fault |

## Verification
The alignment check and the memory strobe act in the same cycle. A misaligned access must cancel the strobe at once, and it must also cancel the writeback that would follow a cycle later. The sweep crosses every operation code with all eight values of the low base-address bits and with displacements that include odd values. This places each load and store at every offset. In the request cycle the strobes and byte mask are compared with an arithmetic model. One cycle later the fault flag and the writeback are checked against the same model.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    OP_ADDR    = 3'd0,
    OP_ADDR_HI = 3'd1,
    OP_LD_LONG = 3'd2,
    OP_LD_QUAD = 3'd3,
    OP_LD_UNAL = 3'd4,
    OP_ST_LONG = 3'd5,
    OP_ST_QUAD = 3'd6,
    OP_NONE    = 3'd7
  } aguOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic useHigh;    // scale displacement
    logic clearLow;   // zero low offset bits of address
    logic wantRead;
    logic wantWrite;
    logic wbAddr;     // write back the address itself
    logic wbLong;     // write back sign-extended half word
    logic sizeQuad;   // full-width access
    logic checkAlign; // natural alignment enforced
  } aguStrobe_t;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic [2:0]                reqOp,
  input  logic [$clog2(DATA_W/8)-1:0] lowBits,
  output aguStrobe_t                strobe,
  output logic                      capture,
  output logic                      memRead,
  output logic                      memWrite,
  output logic [DATA_W/8-1:0]       memByteEn,
  output logic                      wbValid,
  output logic                      alignFault
);

  localparam int BYTES = DATA_W / 8;
  localparam int OFS_W = $clog2(BYTES);
  localparam int HALF_BYTES = BYTES / 2;

  aguOp_e opCode;
  logic   misaligned;
  logic   writesReg;
  logic   accessOn;
  logic   upperHalf;

  assign opCode = aguOp_e'(reqOp);

  always_comb begin
    strobe = '0;
    unique case (opCode)
      OP_ADDR:    strobe.wbAddr = 1'b1;
      OP_ADDR_HI: begin strobe.wbAddr = 1'b1; strobe.useHigh = 1'b1; end
      OP_LD_LONG: begin strobe.wantRead = 1'b1; strobe.wbLong = 1'b1; strobe.checkAlign = 1'b1; end
      OP_LD_QUAD: begin strobe.wantRead = 1'b1; strobe.sizeQuad = 1'b1; strobe.checkAlign = 1'b1; end
      OP_LD_UNAL: begin strobe.wantRead = 1'b1; strobe.sizeQuad = 1'b1; strobe.clearLow = 1'b1; end
      OP_ST_LONG: begin strobe.wantWrite = 1'b1; strobe.checkAlign = 1'b1; end
      OP_ST_QUAD: begin strobe.wantWrite = 1'b1; strobe.sizeQuad = 1'b1; strobe.checkAlign = 1'b1; end
      default:    strobe = '0;
    endcase
  end

  // Natural alignment: full width needs all offset bits clear, half width all but the top one
  always_comb begin
    if (!strobe.checkAlign)
      misaligned = 1'b0;
    else if (strobe.sizeQuad)
      misaligned = |lowBits;
    else
      misaligned = |lowBits[OFS_W-2:0];
  end

  assign writesReg = strobe.wbAddr | strobe.wantRead;
  assign capture   = reqValid & writesReg & ~misaligned;
  assign memRead   = reqValid & strobe.wantRead & ~misaligned;
  assign memWrite  = reqValid & strobe.wantWrite & ~misaligned;
  assign accessOn  = memRead | memWrite;
  assign upperHalf = lowBits[OFS_W-1];

  for (genvar lane = 0; lane < BYTES; lane++) begin : gLane
    localparam bit IN_UPPER = (lane >= HALF_BYTES);
    assign memByteEn[lane] = accessOn & (strobe.sizeQuad | (upperHalf == IN_UPPER));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbValid    <= 1'b0;
      alignFault <= 1'b0;
    end else begin
      wbValid    <= capture;
      alignFault <= reqValid & misaligned;
    end
  end

endmodule

// File: rtl/agu_dpath.sv
module agu_dpath
  import agu_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int DISP_W   = 16,
  parameter int HI_SHIFT = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  aguStrobe_t                  strobe,
  input  logic                        capture,
  input  logic [DATA_W-1:0]           baseVal,
  input  logic [DISP_W-1:0]           disp,
  input  logic [DATA_W-1:0]           storeData,
  input  logic [DATA_W-1:0]           memRdata,
  output logic [DATA_W-1:0]           memAddr,
  output logic [$clog2(DATA_W/8)-1:0] lowBits,
  output logic [DATA_W-1:0]           memWdata,
  output logic [DATA_W-1:0]           wbData
);

  localparam int OFS_W  = $clog2(DATA_W / 8);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] dispExt;
  logic [DATA_W-1:0] dispHigh;
  logic [DATA_W-1:0] effSum;
  logic [HALF_W-1:0] halfSel;
  logic [DATA_W-1:0] longExt;
  logic [DATA_W-1:0] wbNext;

  assign dispExt  = {{(DATA_W-DISP_W){disp[DISP_W-1]}}, disp};
  assign dispHigh = dispExt << HI_SHIFT;
  assign effSum   = baseVal + (strobe.useHigh ? dispHigh : dispExt);
  assign lowBits  = effSum[OFS_W-1:0];
  assign memAddr  = strobe.clearLow ? {effSum[DATA_W-1:OFS_W], {OFS_W{1'b0}}} : effSum;

  assign halfSel  = effSum[OFS_W-1] ? memRdata[DATA_W-1:HALF_W] : memRdata[HALF_W-1:0];
  assign longExt  = {{HALF_W{halfSel[HALF_W-1]}}, halfSel};

  always_comb begin
    if (strobe.wbAddr)      wbNext = effSum;
    else if (strobe.wbLong) wbNext = longExt;
    else                    wbNext = memRdata;
  end

  assign memWdata = strobe.sizeQuad ? storeData : {2{storeData[HALF_W-1:0]}};

  always_ff @(posedge clk) begin
    if (!rstN)
      wbData <= '0;
    else if (capture)
      wbData <= wbNext;
  end

endmodule

// File: rtl/agu_align_top.sv
module agu_align_top
  import agu_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int DISP_W   = 16,
  parameter int HI_SHIFT = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [2:0]          reqOp,
  input  logic [DATA_W-1:0]   baseVal,
  input  logic [DISP_W-1:0]   disp,
  input  logic [DATA_W-1:0]   storeData,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [DATA_W-1:0]   memAddr,
  output logic                memRead,
  output logic                memWrite,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic [DATA_W-1:0]   memWdata,
  output logic                wbValid,
  output logic [DATA_W-1:0]   wbData,
  output logic                alignFault
);

  localparam int OFS_W = $clog2(DATA_W / 8);

  aguStrobe_t       strobe;
  logic             capture;
  logic [OFS_W-1:0] lowBits;

  agu_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .lowBits(lowBits), .strobe(strobe), .capture(capture),
    .memRead(memRead), .memWrite(memWrite), .memByteEn(memByteEn),
    .wbValid(wbValid), .alignFault(alignFault)
  );

  agu_dpath #(.DATA_W(DATA_W), .DISP_W(DISP_W), .HI_SHIFT(HI_SHIFT)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .capture(capture),
    .baseVal(baseVal), .disp(disp), .storeData(storeData), .memRdata(memRdata),
    .memAddr(memAddr), .lowBits(lowBits), .memWdata(memWdata), .wbData(wbData)
  );

endmodule

// File: rtl/agu_align_chk.sv
module agu_align_chk #(
  parameter int DATA_W = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic [2:0]          reqOp,
  input logic [DATA_W-1:0]   memRdata,
  input logic [DATA_W-1:0]   memAddr,
  input logic                memRead,
  input logic                memWrite,
  input logic [DATA_W/8-1:0] memByteEn,
  input logic                wbValid,
  input logic [DATA_W-1:0]   wbData,
  input logic                alignFault
);

  localparam int OFS_W = $clog2(DATA_W / 8);

  // R8, R9: a faulting access never also writes back
  assert_fault_blocks_wb_R8: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> !wbValid);

  // R7: a store strobe only leaves the unit on a naturally aligned address
  assert_store_aligned_R7: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> (memAddr[OFS_W-2:0] == '0) && (!(&memByteEn) || memAddr[OFS_W-1:0] == '0));

  // R6: unaligned quadword load never faults and presents a cleared offset
  assert_unal_nofault_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 3'd4) |=> !alignFault);

  assert_unal_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 3'd4) |-> (memAddr[OFS_W-1:0] == '0) && memRead);

  // R5: aligned quadword load returns the memory word unchanged
  assert_quad_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 3'd3 && memAddr[OFS_W-1:0] == '0) |=> (wbValid && wbData == $past(memRdata)));

  // R10: an idle cycle leaves nothing behind
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!wbValid && !alignFault));

  // R9: read and write strobes are exclusive
  assert_rd_wr_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite));

endmodule

bind agu_align_top agu_align_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
  .memRdata(memRdata), .memAddr(memAddr), .memRead(memRead),
  .memWrite(memWrite), .memByteEn(memByteEn), .wbValid(wbValid),
  .wbData(wbData), .alignFault(alignFault)
);

// File: tb/agu_align_top_tb.sv
module agu_align_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [2:0]  reqOp;
  logic [63:0] baseVal;
  logic [15:0] disp;
  logic [63:0] storeData;
  logic [63:0] memRdata;
  logic [63:0] memAddr;
  logic        memRead;
  logic        memWrite;
  logic [7:0]  memByteEn;
  logic [63:0] memWdata;
  logic        wbValid;
  logic [63:0] wbData;
  logic        alignFault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  agu_align_top dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .baseVal(baseVal), .disp(disp), .storeData(storeData), .memRdata(memRdata),
    .memAddr(memAddr), .memRead(memRead), .memWrite(memWrite),
    .memByteEn(memByteEn), .memWdata(memWdata), .wbValid(wbValid),
    .wbData(wbData), .alignFault(alignFault)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s op=%0d base=%h disp=%h actual=%h expected=%h", req, reqOp, baseVal, disp, act, exp);
    end
  endtask

  task automatic doReq(input logic [2:0] op, input logic [63:0] base, input logic [15:0] d,
                       input logic [63:0] rd, input logic [63:0] sd);
    logic [63:0] ea, expAddr, expWb, expWd;
    logic        isLoad, isStore, isQuad, checkA, bad, expRd, expWr, expWbV;
    logic [7:0]  expBe;
    logic [31:0] half;
    string       tag;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; baseVal = base; disp = d; memRdata = rd; storeData = sd;
    ea = (op == 3'd1) ? base + ({{48{d[15]}}, d} << 16) : base + {{48{d[15]}}, d};
    isLoad  = (op == 3'd2) || (op == 3'd3) || (op == 3'd4);
    isStore = (op == 3'd5) || (op == 3'd6);
    isQuad  = (op == 3'd3) || (op == 3'd4) || (op == 3'd6);
    checkA  = (op == 3'd2) || (op == 3'd3) || isStore;
    bad     = checkA && (isQuad ? (ea[2:0] != 3'd0) : (ea[1:0] != 2'd0));
    expAddr = (op == 3'd4) ? {ea[63:3], 3'b000} : ea;
    expRd   = isLoad && !bad;
    expWr   = isStore && !bad;
    expBe   = (expRd || expWr) ? (isQuad ? 8'hFF : (ea[2] ? 8'hF0 : 8'h0F)) : 8'h00;
    expWd   = (op == 3'd5) ? {sd[31:0], sd[31:0]} : sd;
    half    = ea[2] ? rd[63:32] : rd[31:0];
    expWb   = (op <= 3'd1) ? ea : (op == 3'd2) ? {{32{half[31]}}, half} : rd;
    expWbV  = (op <= 3'd4) && !bad;
    case (op)
      3'd0: tag = "R2"; 3'd1: tag = "R3"; 3'd2: tag = "R4"; 3'd3: tag = "R5";
      3'd4: tag = "R6"; 3'd5, 3'd6: tag = "R7"; default: tag = "R10";
    endcase
    if (bad) tag = isStore ? "R8" : "R9";
    #1;
    chk(memAddr == expAddr, tag, memAddr, expAddr);
    chk(memRead == expRd, tag, {63'd0, memRead}, {63'd0, expRd});
    chk(memWrite == expWr, tag, {63'd0, memWrite}, {63'd0, expWr});
    chk(memByteEn == expBe, tag, {56'd0, memByteEn}, {56'd0, expBe});
    if (expWr) chk(memWdata == expWd, "R7", memWdata, expWd);
    @(negedge clk);
    reqValid = 1'b0;
    chk(alignFault == bad, tag, {63'd0, alignFault}, {63'd0, bad});
    chk(wbValid == expWbV, tag, {63'd0, wbValid}, {63'd0, expWbV});
    if (expWbV) chk(wbData == expWb, tag, wbData, expWb);
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqOp = 3'd0; baseVal = '0; disp = '0;
    storeData = '0; memRdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(wbValid == 1'b0, "R1", {63'd0, wbValid}, 64'd0);
    chk(alignFault == 1'b0, "R1", {63'd0, alignFault}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(wbValid == 1'b0 && alignFault == 1'b0, "R1", {62'd0, wbValid, alignFault}, 64'd0);
    chk(memRead == 1'b0 && memWrite == 1'b0, "R1", {62'd0, memRead, memWrite}, 64'd0);

    for (int op = 0; op < 8; op++) begin
      for (int ofs = 0; ofs < 8; ofs++) begin
        for (int k = 0; k < 6; k++) begin
          logic [15:0] d;
          logic [63:0] rd;
          case (k)
            0: d = 16'h0000; 1: d = 16'h7FFF; 2: d = 16'h8000;
            3: d = 16'hFFF4; 4: d = 16'h0004; default: d = 16'hFFFF;
          endcase
          rd = {(k[0] ? 32'h7ABC_0000 : 32'hF123_0000) + 32'(ofs),
                (k[0] ? 32'h8000_0055 : 32'h1234_0000) + 32'(op)};
          doReq(3'(op), 64'hFEDC_1234_5678_9A00 + 64'(ofs) + 64'(k * 8), d, rd,
                64'hA5A5_0000_C3C3_0000 + 64'(op * 16 + ofs));
        end
      end
    end

    // R10: idle cycle after traffic is quiet
    @(negedge clk);
    chk(wbValid == 1'b0 && alignFault == 1'b0, "R10", {62'd0, wbValid, alignFault}, 64'd0);
    chk(memRead == 1'b0 && memWrite == 1'b0, "R10", {62'd0, memRead, memWrite}, 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule